// File: doc/BRIEF.md
# Floating-Point Invalid Operation Detector

This unit sits beside a single-precision floating-point pipeline. Each strobed request carries an operation code and two 32-bit operands. The unit sorts each operand into one of five classes: zero, finite non-zero, infinity, quiet NaN or signalling NaN. From the classes and the operation it decides whether the request is an invalid operation. It also decides whether the result comes from the special-case path instead of the ordinary arithmetic path.

When the special-case path owns the result, the unit drives the value to store and a destination write strobe. An invalid operation with its trap enabled gives a different outcome: nothing is written and a trap request pulses. Every invalid operation is recorded in a sticky status bit, whatever the trap enable is. Only an explicit clear input resets that bit. Ordinary finite arithmetic and rounding are handled elsewhere. For those requests the unit stays silent and raises no write strobe.

Top module: `fpinv_top`

## Requirements
- R1: An operand is a signalling NaN when its exponent field is all ones, its fraction is non-zero and fraction bit 22 is 0. Any signalling NaN raises invalid (o_inv=1). The operands examined are a alone for square root (op 4) and convert (op 5), and both a and b for every other operation. A quiet NaN alone on add, subtract, multiply or divide raises no invalid and no write.
- R2: Add (op 0) of two infinities of opposite sign is invalid. Subtract (op 1) of two infinities of the same sign is invalid. Add of two infinities of the same sign is not invalid.
- R3: Multiply (op 2) of zero by infinity, in either order, is invalid. Divide (op 3) of zero by zero, and of infinity by infinity, is invalid.
- R4: Square root (op 4) of a negative finite non-zero value or of negative infinity is invalid. Square root of negative zero (0x80000000) raises no invalid, writes 0x80000000 and sets o_wr=1.
- R5: Float-to-integer convert (op 5) is invalid for a NaN, an infinity, or a finite value whose magnitude is at least 2^31. The exception is exactly -2^31 (0xCF000000), which is valid. With the trap masked, the value written is 0x7FFFFFFF for a NaN or positive input and 0x80000000 for a negative input.
- R6: Ordered compare (op 6) with a NaN in either operand is invalid. Quiet compare (op 7) is invalid only for a signalling NaN. Both compares write 0 (false) when either operand is a NaN and no trap is taken.
- R7: Divide of a finite non-zero value by zero is not invalid. It writes an infinity whose sign is the XOR of the operand signs.
- R8: With trap_en=0, an invalid add, subtract, multiply, divide or square root writes the default quiet NaN 0x7FC00000 with o_wr=1 and o_trap=0.
- R9: With trap_en=1, an invalid operation gives o_trap=1 and o_wr=0. A request that is not invalid never gives o_trap=1.
- R10: o_sticky becomes 1 after any invalid operation, with the trap enabled or masked. It returns to 0 only when clr is sampled high. When clr and an invalid request arrive in the same cycle, o_sticky ends at 1.
- R11: o_vld, o_inv, o_trap and o_wr appear exactly one clock after the in_vld strobe and are 0 in cycles with no strobe. After reset all outputs are 0.
- R12: A request that is neither invalid nor one of the special cases above gives o_inv=0, o_wr=0 and o_trap=0. An example is an add of two finite values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Request strobe |
| in_op | input | 3 | Operation: 0 add, 1 sub, 2 mul, 3 div, 4 sqrt, 5 convert, 6 ordered compare, 7 quiet compare |
| in_a | input | 32 | First operand (sole operand of sqrt and convert) |
| in_b | input | 32 | Second operand |
| trap_en | input | 1 | Trap enable for the invalid exception |
| clr | input | 1 | Clears the sticky invalid bit |
| o_vld | output | 1 | Result strobe, one cycle after in_vld |
| o_inv | output | 1 | Invalid operation detected |
| o_trap | output | 1 | Trap request |
| o_wr | output | 1 | Destination write enable for o_data |
| o_data | output | 32 | Special-case result value |
| o_sticky | output | 1 | Sticky invalid status |

## Verification
All flags and the result value are due exactly one clock after the strobe. The sticky bit takes its new value at that same edge. The bench drives each request on a falling edge and removes the strobe at the next falling edge. It samples every output there, half a period after the capturing rising edge, so it always reads the registers just loaded. Idle cycles with no strobe are also sampled, to confirm that no flag lingers.

// File: rtl/fpinv_pkg.sv
package fpinv_pkg;

    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int INT_W  = 32;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_MUL  = 3'd2,
        OP_DIV  = 3'd3,
        OP_SQRT = 3'd4,
        OP_CVT  = 3'd5,
        OP_CMPO = 3'd6,
        OP_CMPQ = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        C_ZERO = 3'd0,
        C_FIN  = 3'd1,
        C_INF  = 3'd2,
        C_QNAN = 3'd3,
        C_SNAN = 3'd4
    } cls_e;

    typedef struct packed {
        cls_e cls;
        logic sign;
    } opnd_t;

    function automatic logic is_nan(opnd_t o);
        return (o.cls == C_QNAN) || (o.cls == C_SNAN);
    endfunction

    function automatic logic uses_b(op_e op);
        return (op != OP_SQRT) && (op != OP_CVT);
    endfunction

endpackage

// File: rtl/fpinv_classify.sv
module fpinv_classify
    import fpinv_pkg::*;
#(
    parameter int EXP_W  = fpinv_pkg::EXP_W,
    parameter int FRAC_W = fpinv_pkg::FRAC_W,
    localparam int W     = EXP_W + FRAC_W + 1
) (
    input  logic [W-1:0] x,
    output opnd_t        info
);

    logic [EXP_W-1:0]  ex;
    logic [FRAC_W-1:0] fr;

    assign ex = x[W-2:FRAC_W];
    assign fr = x[FRAC_W-1:0];

    always_comb begin
        info.sign = x[W-1];
        if (&ex) begin
            if (fr == '0)
                info.cls = C_INF;
            else if (fr[FRAC_W-1])
                info.cls = C_QNAN;
            else
                info.cls = C_SNAN;
        end else if ((ex == '0) && (fr == '0)) begin
            info.cls = C_ZERO;
        end else begin
            info.cls = C_FIN;
        end
    end

endmodule

// File: rtl/fpinv_decide.sv
module fpinv_decide
    import fpinv_pkg::*;
#(
    parameter int EXP_W  = fpinv_pkg::EXP_W,
    parameter int FRAC_W = fpinv_pkg::FRAC_W,
    parameter int INT_W  = fpinv_pkg::INT_W,
    localparam int W     = EXP_W + FRAC_W + 1,
    localparam int BIAS  = (1 << (EXP_W - 1)) - 1
) (
    input  op_e          op,
    input  opnd_t        a,
    input  opnd_t        b,
    input  logic [W-1:0] a_raw,
    output logic         invalid,
    output logic         special,
    output logic [W-1:0] data
);

    localparam logic [EXP_W-1:0] OVF_EXP = EXP_W'(BIAS + INT_W - 1);
    localparam logic [W-1:0] QNAN_DEF = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [W-1:0] INT_MAX  = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] INT_MIN  = {1'b1, {(W-1){1'b0}}};

    logic snan_any, nan_any, both_inf, cvt_ovf, exact_min;
    logic [EXP_W-1:0]  a_ex;
    logic [FRAC_W-1:0] a_fr;

    assign a_ex = a_raw[W-2:FRAC_W];
    assign a_fr = a_raw[FRAC_W-1:0];

    always_comb begin
        snan_any  = (a.cls == C_SNAN) || (uses_b(op) && (b.cls == C_SNAN));
        nan_any   = is_nan(a) || is_nan(b);
        both_inf  = (a.cls == C_INF) && (b.cls == C_INF);
        exact_min = a_raw[W-1] && (a_ex == OVF_EXP) && (a_fr == '0);
        cvt_ovf   = (a.cls == C_FIN) && (a_ex >= OVF_EXP) && !exact_min;

        invalid = snan_any;
        special = 1'b0;
        data    = '0;

        unique case (op)
            OP_ADD, OP_SUB: begin
                if (both_inf && (a.sign ^ b.sign ^ (op == OP_SUB)))
                    invalid = 1'b1;
                special = invalid;
                data    = QNAN_DEF;
            end
            OP_MUL: begin
                if (((a.cls == C_ZERO) && (b.cls == C_INF)) ||
                    ((a.cls == C_INF) && (b.cls == C_ZERO)))
                    invalid = 1'b1;
                special = invalid;
                data    = QNAN_DEF;
            end
            OP_DIV: begin
                if (((a.cls == C_ZERO) && (b.cls == C_ZERO)) || both_inf)
                    invalid = 1'b1;
                if (invalid) begin
                    special = 1'b1;
                    data    = QNAN_DEF;
                end else if ((a.cls == C_FIN) && (b.cls == C_ZERO)) begin
                    special = 1'b1;
                    data    = {a.sign ^ b.sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
                end
            end
            OP_SQRT: begin
                if (a.sign && ((a.cls == C_FIN) || (a.cls == C_INF)))
                    invalid = 1'b1;
                if (invalid) begin
                    special = 1'b1;
                    data    = QNAN_DEF;
                end else if (a.sign && (a.cls == C_ZERO)) begin
                    special = 1'b1;
                    data    = INT_MIN;
                end
            end
            OP_CVT: begin
                if (is_nan(a) || (a.cls == C_INF) || cvt_ovf)
                    invalid = 1'b1;
                special = invalid;
                data    = (is_nan(a) || !a.sign) ? INT_MAX : INT_MIN;
            end
            OP_CMPO, OP_CMPQ: begin
                if ((op == OP_CMPO) && nan_any)
                    invalid = 1'b1;
                special = nan_any;
                data    = '0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/fpinv_top.sv
module fpinv_top
    import fpinv_pkg::*;
#(
    parameter int EXP_W  = fpinv_pkg::EXP_W,
    parameter int FRAC_W = fpinv_pkg::FRAC_W,
    parameter int INT_W  = fpinv_pkg::INT_W,
    localparam int W     = EXP_W + FRAC_W + 1,
    localparam int N_OPND = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_vld,
    input  logic [2:0]   in_op,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    input  logic         trap_en,
    input  logic         clr,
    output logic         o_vld,
    output logic         o_inv,
    output logic         o_trap,
    output logic         o_wr,
    output logic [W-1:0] o_data,
    output logic         o_sticky
);

    logic [W-1:0] raw [N_OPND];
    opnd_t        cls [N_OPND];
    op_e          op;
    logic         d_inv, d_spec, take_trap;
    logic [W-1:0] d_data;

    assign raw[0] = in_a;
    assign raw[1] = in_b;
    assign op     = op_e'(in_op);

    for (genvar gi = 0; gi < N_OPND; gi++) begin : g_cls
        fpinv_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .x    (raw[gi]),
            .info (cls[gi])
        );
    end

    fpinv_decide #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_dec (
        .op      (op),
        .a       (cls[0]),
        .b       (cls[1]),
        .a_raw   (in_a),
        .invalid (d_inv),
        .special (d_spec),
        .data    (d_data)
    );

    assign take_trap = d_inv && trap_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            o_vld    <= 1'b0;
            o_inv    <= 1'b0;
            o_trap   <= 1'b0;
            o_wr     <= 1'b0;
            o_data   <= '0;
            o_sticky <= 1'b0;
        end else begin
            o_vld    <= in_vld;
            o_inv    <= in_vld && d_inv;
            o_trap   <= in_vld && take_trap;
            o_wr     <= in_vld && d_spec && !take_trap;
            if (in_vld)
                o_data <= take_trap ? '0 : d_data;
            o_sticky <= (o_sticky && !clr) || (in_vld && d_inv);
        end
    end

    AST_TRAP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        o_trap |-> (o_inv && !o_wr)); // R9

    AST_FLAGS_NEED_VLD: assert property (@(posedge clk) disable iff (rst)
        (o_inv || o_trap || o_wr) |-> o_vld); // R11

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> o_vld); // R11

    AST_STICKY_RECORDS: assert property (@(posedge clk) disable iff (rst)
        o_inv |-> o_sticky); // R10

    AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (o_sticky && !clr) |=> o_sticky); // R10

    AST_DIV0_SAFE: assert property (@(posedge clk) disable iff (rst)
        (in_vld && (op == OP_DIV) && (cls[0].cls == C_FIN) && (cls[1].cls == C_ZERO))
        |=> (o_vld && !o_inv)); // R7

    AST_SQRT_NEGZERO: assert property (@(posedge clk) disable iff (rst)
        (in_vld && (op == OP_SQRT) && (cls[0].cls == C_ZERO) && cls[0].sign)
        |=> (o_vld && !o_inv && o_wr)); // R4

    AST_SNAN_INVALID: assert property (@(posedge clk) disable iff (rst)
        (in_vld && (cls[0].cls == C_SNAN)) |=> o_inv); // R1

endmodule

// File: tb/sim_fpinv_top.sv
module sim_fpinv_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_vld = 1'b0;
    logic [2:0]  in_op = 3'd0;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        trap_en = 1'b0;
    logic        clr = 1'b0;
    logic        o_vld, o_inv, o_trap, o_wr, o_sticky;
    logic [31:0] o_data;

    int checks = 0;
    int failures = 0;
    logic m_sticky = 1'b0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpinv_top u0 (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_op(in_op), .in_a(in_a), .in_b(in_b),
        .trap_en(trap_en), .clr(clr), .o_vld(o_vld), .o_inv(o_inv), .o_trap(o_trap),
        .o_wr(o_wr), .o_data(o_data), .o_sticky(o_sticky)
    );

    function automatic bit f_nan(logic [31:0] x);  return x[30:23] == 8'hFF && x[22:0] != 0; endfunction
    function automatic bit f_snan(logic [31:0] x); return f_nan(x) && !x[22]; endfunction
    function automatic bit f_inf(logic [31:0] x);  return x[30:0] == 31'h7F800000; endfunction
    function automatic bit f_zero(logic [31:0] x); return x[30:0] == 0; endfunction
    function automatic bit f_fnz(logic [31:0] x);  return x[30:23] != 8'hFF && !f_zero(x); endfunction

    // expected {invalid, special, value} from the requirement text
    function automatic logic [33:0] ref_model(logic [2:0] op, logic [31:0] a, logic [31:0] b);
        bit inv, spec;
        logic [31:0] v;
        bit two = (op != 3'd4) && (op != 3'd5);
        inv  = f_snan(a) || (two && f_snan(b));
        spec = 0;
        v    = 32'h7FC00000;
        case (op)
            3'd0: if (f_inf(a) && f_inf(b) && a[31] != b[31]) inv = 1;
            3'd1: if (f_inf(a) && f_inf(b) && a[31] == b[31]) inv = 1;
            3'd2: if ((f_zero(a) && f_inf(b)) || (f_inf(a) && f_zero(b))) inv = 1;
            3'd3: begin
                if ((f_zero(a) && f_zero(b)) || (f_inf(a) && f_inf(b))) inv = 1;
                if (!inv && f_fnz(a) && f_zero(b)) begin spec = 1; v = {a[31] ^ b[31], 31'h7F800000}; end
            end
            3'd4: begin
                if (a[31] && !f_nan(a) && !f_zero(a)) inv = 1;
                if (!inv && a == 32'h80000000) begin spec = 1; v = 32'h80000000; end
            end
            3'd5: begin
                if (f_nan(a) || f_inf(a) || (a[30:23] >= 8'd158 && a != 32'hCF000000)) inv = 1;
                v = (f_nan(a) || !a[31]) ? 32'h7FFFFFFF : 32'h80000000;
            end
            default: begin
                if (op == 3'd6 && (f_nan(a) || f_nan(b))) inv = 1;
                spec = f_nan(a) || f_nan(b);
                v = 32'h0;
            end
        endcase
        if (inv) spec = 1;
        return {inv, spec, v};
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic run(logic [2:0] op, logic [31:0] a, logic [31:0] b, logic te, logic cl, string tag);
        logic [33:0] r;
        bit e_inv, e_spec, e_trap, e_wr;
        @(negedge clk);
        in_vld = 1; in_op = op; in_a = a; in_b = b; trap_en = te; clr = cl;
        r = ref_model(op, a, b);
        e_inv  = r[33];
        e_spec = r[32];
        e_trap = e_inv && te;
        e_wr   = e_spec && !e_trap;
        m_sticky = (m_sticky && !cl) || e_inv;
        @(negedge clk);
        in_vld = 0; clr = 0;
        chk({tag, " vld"}, 32'(o_vld), 32'd1);
        chk({tag, " inv"}, 32'(o_inv), 32'(e_inv));
        chk({tag, " trap"}, 32'(o_trap), 32'(e_trap));
        chk({tag, " wr"}, 32'(o_wr), 32'(e_wr));
        if (e_wr) chk({tag, " data"}, o_data, r[31:0]);
        chk({tag, " sticky R10"}, 32'(o_sticky), 32'(m_sticky));
    endtask

    function automatic logic [31:0] pick();
        logic [31:0] lst [10] = '{32'h0, 32'h80000000, 32'h7F800000, 32'hFF800000, 32'h7FC00000,
                                  32'hFF800001, 32'h3F800000, 32'h4F000000, 32'hCF000000, 32'hBF800000};
        if ($urandom % 3 != 0) return lst[$urandom % 10];
        return $urandom;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog R11 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk("R11 reset vld", 32'(o_vld), 0);
        chk("R11 reset wr", 32'(o_wr), 0);
        chk("R11 reset sticky", 32'(o_sticky), 0);
        @(negedge clk); rst = 0;

        run(3'd0, 32'h7F800001, 32'h3F800000, 0, 0, "R1 snan add");
        run(3'd4, 32'h3F800000, 32'h7F800001, 0, 1, "R1 sqrt ignores b");
        run(3'd0, 32'h7FC00000, 32'h3F800000, 0, 0, "R1 qnan add quiet");
        run(3'd0, 32'h7F800000, 32'hFF800000, 0, 0, "R2 add opp inf");
        run(3'd1, 32'hFF800000, 32'hFF800000, 1, 0, "R2 sub same inf");
        run(3'd0, 32'h7F800000, 32'h7F800000, 0, 1, "R2 add same inf");
        run(3'd2, 32'h00000000, 32'hFF800000, 0, 0, "R3 mul zero inf");
        run(3'd2, 32'h7F800000, 32'h80000000, 0, 0, "R3 mul inf zero");
        run(3'd3, 32'h80000000, 32'h00000000, 0, 0, "R3 div zero zero");
        run(3'd3, 32'h7F800000, 32'hFF800000, 0, 1, "R3 div inf inf");
        run(3'd4, 32'hBF800000, 32'h0, 0, 0, "R4 sqrt neg");
        run(3'd4, 32'h80000000, 32'h0, 0, 1, "R4 sqrt negzero");
        run(3'd4, 32'hFF800000, 32'h0, 1, 0, "R4 sqrt neg inf trap");
        run(3'd5, 32'h4F000000, 32'h0, 0, 0, "R5 cvt pos ovf");
        run(3'd5, 32'hCF000000, 32'h0, 0, 0, "R5 cvt exact min");
        run(3'd5, 32'hCF000001, 32'h0, 0, 0, "R5 cvt neg ovf");
        run(3'd5, 32'hFFC00000, 32'h0, 0, 0, "R5 cvt nan");
        run(3'd5, 32'h4EFFFFFF, 32'h0, 0, 0, "R5 cvt max fit");
        run(3'd6, 32'h3F800000, 32'h7FC00000, 0, 1, "R6 cmpo qnan");
        run(3'd7, 32'h3F800000, 32'h7FC00000, 0, 0, "R6 cmpq qnan");
        run(3'd7, 32'h7F800001, 32'h0, 0, 0, "R6 cmpq snan");
        run(3'd3, 32'hBF800000, 32'h00000000, 0, 1, "R7 div by zero neg");
        run(3'd3, 32'h3F800000, 32'h80000000, 1, 0, "R7 div by negzero");
        run(3'd2, 32'h7F800000, 32'h00000000, 0, 1, "R8 masked qnan");
        run(3'd1, 32'h7F800000, 32'h7F800000, 1, 1, "R9 trap clr same cycle R10");
        run(3'd0, 32'h3F800000, 32'hBF800000, 1, 1, "R12 finite add clr");
        @(negedge clk);
        chk("R11 idle vld", 32'(o_vld), 0);
        chk("R11 idle inv", 32'(o_inv), 0);
        chk("R10 sticky hold idle", 32'(o_sticky), 32'(m_sticky));

        for (int i = 0; i < 400; i++) begin
            logic [2:0] op = 3'($urandom % 8);
            logic [31:0] a = pick();
            logic [31:0] b = pick();
            run(op, a, b, 1'($urandom % 2), ($urandom % 8) == 0, "R12 random");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule